// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which of several interrupt sources the processor takes next. Each maskable source has a programmable 3-bit priority level and a request bit that a one-cycle set pulse latches. The block holds the processor's current interrupt priority level and an interrupt-disable flag. A maskable request is taken only when the flag is clear and the request's level is strictly above the current priority level. A request that loses this comparison stays pending until the priority level drops.

On every acceptance the block pushes the current priority level and disable flag onto an internal save stack. It then loads the new level, sets the disable flag and clears the request. It reports the winning source with a one-cycle acknowledge pulse. A return strobe pops the stack, so a handler that clears the disable flag can be preempted by a higher-level source and later resume. Three fault sources (watchdog, divide by zero, address match) bypass both the flag and the level check.

Top module: `nested_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `reqSet[i]` sets pending bit i, which shows on `pendingReq` after that clock edge. The bit stays set until source i is accepted.
- R2: A pending maskable source is accepted only when `disableFlag` is 0 and its level is strictly greater than `ipl`. Acceptance happens on the clock edge after the request is seen as pending. `ackValid` is then high for exactly one cycle, with `ackIsNmi`=0 and `ackIndex` equal to the source number.
- R3: On a maskable acceptance, `disableFlag` becomes 1, the source's pending bit is cleared, and `ipl` takes the source's level.
- R4: A pending request whose level is not above `ipl` is kept pending and is not discarded.
- R5: Among eligible sources the highest level wins. When levels are equal, the lowest-numbered source wins.
- R6: A source programmed to level 0 is never accepted, but its request stays pending.
- R7: Clearing `disableFlag` through `flagClr` inside a handler lets a source with a level above the current `ipl` preempt it.
- R8: A `retStrobe` restores the `ipl` and `disableFlag` saved at the latest unreturned acceptance. No acceptance occurs in the cycle of the strobe. A held request is then taken if its level exceeds the restored `ipl`.
- R9: Fault sources latched through `nmiSet` are accepted regardless of `disableFlag` and `ipl`, and ahead of any maskable source. The order among them is bit 0 watchdog (index 0), then bit 1 divide by zero (index 1), then bit 2 address match (index 2). Each is acknowledged with `ackIsNmi`=1 and sets `ipl` to 7 and `disableFlag` to 1.
- R10: The save stack holds 8 entries. A ninth nested acceptance without a return is still acknowledged, but nothing is saved for it, and the sticky `stackOverflow` output is set.
- R11: A `retStrobe` while the save stack is empty leaves `ipl` and `disableFlag` unchanged.
- R12: At most one source is accepted per cycle. Several pending fault sources are acknowledged on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; ipl=0, disableFlag=1, all levels 0 |
| reqSet | input | NUM_SRC | One pulse per maskable source, latches its request |
| nmiSet | input | 3 | Fault request pulses: bit0 watchdog, bit1 divide by zero, bit2 address match |
| lvlWrEn | input | 1 | Writes lvlWrData as the level of source lvlWrSel |
| lvlWrSel | input | IDX_W | Source number for a level write |
| lvlWrData | input | LVL_W | Priority level to write |
| flagSet | input | 1 | Sets the disable flag |
| flagClr | input | 1 | Clears the disable flag (takes precedence over flagSet) |
| retStrobe | input | 1 | Return-from-interrupt strobe |
| ackValid | output | 1 | One-cycle acceptance pulse |
| ackIsNmi | output | 1 | Accepted source is a fault source |
| ackIndex | output | IDX_W | Index of the accepted source |
| ipl | output | LVL_W | Current processor interrupt priority level |
| disableFlag | output | 1 | Interrupt disable flag |
| pendingReq | output | NUM_SRC | Latched maskable requests |
| stackOverflow | output | 1 | Sticky save-stack overflow flag |

## Verification
The bench builds the block with its defaults: eight maskable sources, 3-bit levels and an 8-entry save stack. These values allow the full range of levels from 0 through 7, ties between sources, and a stack that fills after eight nested acceptances. A ninth fault acceptance therefore reaches the overflow path, and nine returns walk the stack back to empty and one step beyond. Nesting depth reaches four in the fault scenario, where the stack unwinds through repeated priority-level-7 entries back to a held request.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int NMI_COUNT = 3;

  typedef struct packed {
    logic takeMask;
    logic takeNmi;
    logic push;
    logic pop;
  } ipcStrobes_t;
endpackage

// File: rtl/ipc_datapath.sv
module ipc_datapath
  import ipc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int LVL_W       = 3,
  parameter int STACK_DEPTH = 8,
  parameter int IDX_W       = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    reqSet,
  input  logic [NMI_COUNT-1:0]  nmiSet,
  input  logic                  lvlWrEn,
  input  logic [IDX_W-1:0]      lvlWrSel,
  input  logic [LVL_W-1:0]      lvlWrData,
  input  logic                  flagSet,
  input  logic                  flagClr,
  input  ipcStrobes_t           strobes,
  output logic [LVL_W-1:0]      ipl,
  output logic                  disableFlag,
  output logic [NUM_SRC-1:0]    pendingReq,
  output logic                  maskValid,
  output logic [IDX_W-1:0]      maskIdx,
  output logic                  nmiValid,
  output logic [1:0]            nmiIdx,
  output logic                  stackEmpty,
  output logic                  stackFull
);
  localparam int SP_W = $clog2(STACK_DEPTH + 1);

  logic [LVL_W-1:0]     srcLevel [NUM_SRC];
  logic [LVL_W-1:0]     maskLvl;
  logic [NMI_COUNT-1:0] nmiPend;
  logic [LVL_W-1:0]     stkIpl [STACK_DEPTH];
  logic                 stkFlg [STACK_DEPTH];
  logic [SP_W-1:0]      stackPtr;
  logic [SP_W-1:0]      spDec;
  logic [LVL_W-1:0]     topIpl;
  logic                 topFlg;

  // Per-source level register and request latch
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcLevel[g]   <= '0;
        pendingReq[g] <= 1'b0;
      end else begin
        if (lvlWrEn && lvlWrSel == IDX_W'(g))
          srcLevel[g] <= lvlWrData;
        if (reqSet[g])
          pendingReq[g] <= 1'b1;
        else if (strobes.takeMask && maskIdx == IDX_W'(g))
          pendingReq[g] <= 1'b0;
      end
    end
  end

  // Highest level wins; strict compare keeps the lowest index on ties
  always_comb begin
    maskLvl = '0;
    maskIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pendingReq[i] && srcLevel[i] > maskLvl) begin
        maskLvl = srcLevel[i];
        maskIdx = IDX_W'(i);
      end
    end
    maskValid = maskLvl > ipl;
  end

  // Fault sources: fixed order
  always_comb begin
    nmiValid = |nmiPend;
    if (nmiPend[0])      nmiIdx = 2'd0;
    else if (nmiPend[1]) nmiIdx = 2'd1;
    else                 nmiIdx = 2'd2;
  end

  for (genvar n = 0; n < NMI_COUNT; n++) begin : g_nmi
    always_ff @(posedge clk) begin
      if (!rstN)
        nmiPend[n] <= 1'b0;
      else if (nmiSet[n])
        nmiPend[n] <= 1'b1;
      else if (strobes.takeNmi && nmiIdx == 2'(n))
        nmiPend[n] <= 1'b0;
    end
  end

  // Save stack
  assign stackEmpty = (stackPtr == '0);
  assign stackFull  = (stackPtr == SP_W'(STACK_DEPTH));
  assign spDec      = stackPtr - 1'b1;

  always_comb begin
    topIpl = '0;
    topFlg = 1'b0;
    for (int e = 0; e < STACK_DEPTH; e++) begin
      if (spDec == SP_W'(e)) begin
        topIpl = stkIpl[e];
        topFlg = stkFlg[e];
      end
    end
  end

  for (genvar e = 0; e < STACK_DEPTH; e++) begin : g_stk
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stkIpl[e] <= '0;
        stkFlg[e] <= 1'b0;
      end else if (strobes.push && stackPtr == SP_W'(e)) begin
        stkIpl[e] <= ipl;
        stkFlg[e] <= disableFlag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      stackPtr <= '0;
    else if (strobes.push)
      stackPtr <= stackPtr + 1'b1;
    else if (strobes.pop)
      stackPtr <= spDec;
  end

  // Processor priority level and disable flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ipl         <= '0;
      disableFlag <= 1'b1;
    end else if (strobes.takeMask) begin
      ipl         <= maskLvl;
      disableFlag <= 1'b1;
    end else if (strobes.takeNmi) begin
      ipl         <= '1;
      disableFlag <= 1'b1;
    end else if (strobes.pop) begin
      ipl         <= topIpl;
      disableFlag <= topFlg;
    end else if (flagClr) begin
      disableFlag <= 1'b0;
    end else if (flagSet) begin
      disableFlag <= 1'b1;
    end
  end

  // R3: acceptance loads the level and masks further requests
  a_r3_accept_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeMask |=> (disableFlag && ipl == $past(maskLvl)));

  // R3: the accepted request bit drops unless re-requested
  a_r3_clear_req: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeMask && !reqSet[maskIdx]) |=> !pendingReq[$past(maskIdx)]);

  // R9: fault acceptance raises the level to the top
  a_r9_nmi_level: assert property (@(posedge clk) disable iff (!rstN)
    strobes.takeNmi |=> (ipl == '1 && disableFlag));

  // R8: a return removes exactly one stack entry
  a_r8_pop_depth: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |=> stackPtr == $past(stackPtr) - 1'b1);

  // R12: no more than one request retires per cycle
  a_r12_one_retire: assert property (@(posedge clk) disable iff (!rstN)
    $countones({$past(pendingReq) & ~pendingReq, $past(nmiPend) & ~nmiPend}) <= 1);
endmodule

// File: rtl/ipc_control.sv
module ipc_control
  import ipc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retStrobe,
  input  logic             disableFlag,
  input  logic             maskValid,
  input  logic [IDX_W-1:0] maskIdx,
  input  logic             nmiValid,
  input  logic [1:0]       nmiIdx,
  input  logic             stackEmpty,
  input  logic             stackFull,
  output ipcStrobes_t      strobes,
  output logic             ackValid,
  output logic             ackIsNmi,
  output logic [IDX_W-1:0] ackIndex,
  output logic             stackOverflow
);
  logic takeAny;

  always_comb begin
    strobes.takeNmi  = nmiValid && !retStrobe;
    strobes.takeMask = maskValid && !disableFlag && !retStrobe && !nmiValid;
    takeAny          = strobes.takeNmi || strobes.takeMask;
    strobes.push     = takeAny && !stackFull;
    strobes.pop      = retStrobe && !stackEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackValid      <= 1'b0;
      ackIsNmi      <= 1'b0;
      ackIndex      <= '0;
      stackOverflow <= 1'b0;
    end else begin
      ackValid <= takeAny;
      ackIsNmi <= strobes.takeNmi;
      if (takeAny)
        ackIndex <= strobes.takeNmi ? IDX_W'(nmiIdx) : maskIdx;
      if (takeAny && stackFull)
        stackOverflow <= 1'b1;
    end
  end

  // R10: acceptance on a full stack raises the overflow flag
  a_r10_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (takeAny && stackFull) |=> stackOverflow);

  // R10: overflow flag never falls outside reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    stackOverflow |=> stackOverflow);

  // R8: no acknowledge follows a return cycle
  a_r8_ret_blocks_ack: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe |=> !ackValid);
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import ipc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int LVL_W       = 3,
  parameter int STACK_DEPTH = 8,
  localparam int SRC_W      = $clog2(NUM_SRC),
  localparam int IDX_W      = (SRC_W < 2) ? 2 : SRC_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   reqSet,
  input  logic [NMI_COUNT-1:0] nmiSet,
  input  logic                 lvlWrEn,
  input  logic [IDX_W-1:0]     lvlWrSel,
  input  logic [LVL_W-1:0]     lvlWrData,
  input  logic                 flagSet,
  input  logic                 flagClr,
  input  logic                 retStrobe,
  output logic                 ackValid,
  output logic                 ackIsNmi,
  output logic [IDX_W-1:0]     ackIndex,
  output logic [LVL_W-1:0]     ipl,
  output logic                 disableFlag,
  output logic [NUM_SRC-1:0]   pendingReq,
  output logic                 stackOverflow
);
  ipcStrobes_t      strobes;
  logic             maskValid;
  logic [IDX_W-1:0] maskIdx;
  logic             nmiValid;
  logic [1:0]       nmiIdx;
  logic             stackEmpty;
  logic             stackFull;

  ipc_datapath #(
    .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .STACK_DEPTH(STACK_DEPTH), .IDX_W(IDX_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .nmiSet(nmiSet),
    .lvlWrEn(lvlWrEn), .lvlWrSel(lvlWrSel), .lvlWrData(lvlWrData),
    .flagSet(flagSet), .flagClr(flagClr), .strobes(strobes),
    .ipl(ipl), .disableFlag(disableFlag), .pendingReq(pendingReq),
    .maskValid(maskValid), .maskIdx(maskIdx), .nmiValid(nmiValid),
    .nmiIdx(nmiIdx), .stackEmpty(stackEmpty), .stackFull(stackFull)
  );

  ipc_control #(.IDX_W(IDX_W)) u_control (
    .clk(clk), .rstN(rstN), .retStrobe(retStrobe), .disableFlag(disableFlag),
    .maskValid(maskValid), .maskIdx(maskIdx), .nmiValid(nmiValid),
    .nmiIdx(nmiIdx), .stackEmpty(stackEmpty), .stackFull(stackFull),
    .strobes(strobes), .ackValid(ackValid), .ackIsNmi(ackIsNmi),
    .ackIndex(ackIndex), .stackOverflow(stackOverflow)
  );
endmodule

// File: tb/nested_irq_ctrl_tb.sv
module nested_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqSet = '0;
  logic [2:0] nmiSet = '0;
  logic       lvlWrEn = 1'b0;
  logic [2:0] lvlWrSel = '0;
  logic [2:0] lvlWrData = '0;
  logic       flagSet = 1'b0;
  logic       flagClr = 1'b0;
  logic       retStrobe = 1'b0;
  logic       ackValid, ackIsNmi, disableFlag, stackOverflow;
  logic [2:0] ackIndex, ipl;
  logic [7:0] pendingReq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nested_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .nmiSet(nmiSet),
    .lvlWrEn(lvlWrEn), .lvlWrSel(lvlWrSel), .lvlWrData(lvlWrData),
    .flagSet(flagSet), .flagClr(flagClr), .retStrobe(retStrobe),
    .ackValid(ackValid), .ackIsNmi(ackIsNmi), .ackIndex(ackIndex),
    .ipl(ipl), .disableFlag(disableFlag), .pendingReq(pendingReq),
    .stackOverflow(stackOverflow)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setLevel(input int src, input int lvl);
    lvlWrEn = 1'b1; lvlWrSel = 3'(src); lvlWrData = 3'(lvl);
    @(negedge clk);
    lvlWrEn = 1'b0;
  endtask

  task automatic pulseReq(input logic [7:0] bits);
    reqSet = bits;
    @(negedge clk);
    reqSet = '0;
  endtask

  task automatic pulseNmi(input logic [2:0] bits);
    nmiSet = bits;
    @(negedge clk);
    nmiSet = '0;
  endtask

  task automatic pulseRet();
    retStrobe = 1'b1;
    @(negedge clk);
    retStrobe = 1'b0;
  endtask

  task automatic pulseFlag(input bit clr);
    if (clr) flagClr = 1'b1; else flagSet = 1'b1;
    @(negedge clk);
    flagClr = 1'b0; flagSet = 1'b0;
  endtask

  task automatic expectAck(input string tag, input int isNmi, input int idx, input int lvl);
    @(negedge clk);
    checkEq({tag, " ackValid"}, ackValid, 1);
    checkEq({tag, " ackIsNmi"}, ackIsNmi, isNmi);
    checkEq({tag, " ackIndex"}, ackIndex, idx);
    checkEq({tag, " ipl"}, ipl, lvl);
    checkEq({tag, " disableFlag"}, disableFlag, 1);
  endtask

  task automatic expectState(input string tag, input int lvl, input int flg);
    checkEq({tag, " ipl"}, ipl, lvl);
    checkEq({tag, " disableFlag"}, disableFlag, flg);
  endtask

  task automatic testReset();
    expectState("reset", 0, 1);
    checkEq("reset pendingReq", pendingReq, 0);
    checkEq("reset ackValid", ackValid, 0);
    checkEq("reset stackOverflow", stackOverflow, 0);
  endtask

  // R1 R2 R3: latch, gating by flag, acceptance effects
  task automatic testBasic();
    setLevel(3, 4); setLevel(1, 6); setLevel(5, 2);
    setLevel(2, 5); setLevel(6, 5); setLevel(4, 3);
    pulseReq(8'h08);
    checkEq("R1 pending latched", pendingReq[3], 1);
    repeat (2) begin
      @(negedge clk);
      checkEq("R2 flag blocks ack", ackValid, 0);
    end
    checkEq("R1 pending held", pendingReq[3], 1);
    pulseFlag(1'b1);
    checkEq("R2 no ack in flag-clear cycle", ackValid, 0);
    expectAck("R2 R3 accept src3", 0, 3, 4);
    checkEq("R3 pending cleared", pendingReq[3], 0);
    @(negedge clk);
    checkEq("R2 ack one cycle", ackValid, 0);
    pulseRet();
    expectState("R8 restore after src3", 0, 0);
  endtask

  // R4 R8: low-level request held then taken after return
  task automatic testRetained();
    pulseReq(8'h02);
    expectAck("R3 accept src1", 0, 1, 6);
    pulseFlag(1'b1);
    pulseReq(8'h20);
    repeat (3) begin
      @(negedge clk);
      checkEq("R4 low level not taken", ackValid, 0);
    end
    checkEq("R4 low level kept", pendingReq[5], 1);
    pulseRet();
    expectState("R8 restored before retained", 0, 0);
    checkEq("R8 no ack in ret cycle", ackValid, 0);
    expectAck("R8 retained src5", 0, 5, 2);
    pulseRet();
    expectState("R8 back to base", 0, 0);
  endtask

  // R7: nested preemption
  task automatic testNesting();
    pulseReq(8'h20);
    expectAck("R7 outer src5", 0, 5, 2);
    pulseFlag(1'b1);
    pulseReq(8'h02);
    expectAck("R7 preempt by src1", 0, 1, 6);
    pulseRet();
    expectState("R7 inner return", 2, 0);
    pulseRet();
    expectState("R7 outer return", 0, 0);
  endtask

  // R5: highest level, then lowest index
  task automatic testTie();
    pulseFlag(1'b0);
    pulseReq(8'h54);
    pulseFlag(1'b1);
    expectAck("R5 tie lowest index", 0, 2, 5);
    @(negedge clk);
    checkEq("R5 others pending", pendingReq, 8'h50);
    pulseRet();
    expectAck("R5 second of tie", 0, 6, 5);
    pulseRet();
    expectAck("R5 lower level last", 0, 4, 3);
    pulseRet();
    expectState("R5 all done", 0, 0);
    checkEq("R5 none pending", pendingReq, 0);
  endtask

  // R6: level 0 never accepted
  task automatic testLevelZero();
    pulseReq(8'h80);
    repeat (4) begin
      @(negedge clk);
      checkEq("R6 level0 no ack", ackValid, 0);
    end
    checkEq("R6 level0 stays pending", pendingReq[7], 1);
    setLevel(7, 1);
    expectAck("R6 taken once level set", 0, 7, 1);
    pulseRet();
  endtask

  // R9 R12: fault sources
  task automatic testNmi();
    pulseReq(8'h02);
    expectAck("R9 base handler src1", 0, 1, 6);
    pulseReq(8'h04);
    pulseNmi(3'b111);
    expectAck("R9 R12 watchdog first", 1, 0, 7);
    expectAck("R9 R12 divide next", 1, 1, 7);
    expectAck("R9 R12 address last", 1, 2, 7);
    checkEq("R9 src2 still pending", pendingReq[2], 1);
    pulseRet();
    expectState("R9 pop 1", 7, 1);
    pulseRet();
    expectState("R9 pop 2", 7, 1);
    pulseRet();
    expectState("R9 pop 3", 6, 1);
    pulseRet();
    expectState("R9 pop 4", 0, 0);
    expectAck("R8 retained src2 after faults", 0, 2, 5);
    pulseRet();
  endtask

  // R11 R10: empty return and overflow
  task automatic testStack();
    pulseFlag(1'b0);
    pulseRet();
    @(negedge clk);
    expectState("R11 empty return ignored", 0, 1);
    pulseFlag(1'b1);
    for (int k = 0; k < 9; k++) begin
      pulseNmi(3'b001);
      expectAck("R10 nested fault", 1, 0, 7);
      checkEq("R10 overflow flag", stackOverflow, (k == 8) ? 1 : 0);
    end
    for (int k = 0; k < 8; k++) pulseRet();
    expectState("R10 unwound to base", 0, 0);
    pulseRet();
    @(negedge clk);
    expectState("R11 extra return ignored", 0, 0);
    checkEq("R10 overflow sticky", stackOverflow, 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testRetained();
    testNesting();
    testTie();
    testLevelZero();
    testNmi();
    testStack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule